// File: doc/BRIEF.md
# Approximate four-to-two compressor slice

This block is one column of a partial-product reduction tree. It takes four bits of equal weight and, depending on a compile-time variant, a carry from the column to its right. It returns a sum bit of weight one and two bits of weight two. The carry bit stays in the next row of the same tree. The carry-out bit goes to the column on the left.

Variant 0 is an exact compressor. Variants 1 and 2 are approximate. They give wrong results on a few input patterns, and in exchange their logic is shallower.

- Variant 1 keeps the column-to-column carry pins. Its carry bit is simply the incoming carry.
- Variant 2 has no carry chain: the carry-in pin is ignored and the carry-out pin is held low.

A signed difference output reports the approximate value minus the exact value. It exists for error analysis and can be left unconnected.

Top module: `cmp42_slice`

## Requirements
- R1: With VARIANT=0, the weighted output sum_o + 2*carry_o + 2*carry_out equals the number of ones among bits_in[3:0] plus carry_in, for all 32 input combinations.
- R2: With VARIANT=0, carry_out is the majority of bits_in[0], bits_in[1] and bits_in[2], and does not depend on carry_in.
- R3: With VARIANT=1, carry_o equals carry_in for every input.
- R4: With VARIANT=1, sum_o is 0 whenever carry_in is 1. When carry_in is 0, sum_o is 1 exactly when bits_in[0] equals bits_in[1] or bits_in[2] equals bits_in[3].
- R5: With VARIANT=1, carry_out is (bits_in[0] OR bits_in[1]) AND (bits_in[2] OR bits_in[3]).
- R6: With VARIANT=1, exactly 12 of the 32 input combinations give a weighted value different from the exact one. All-zero inputs with carry_in=0 give sum_o=1, a value of 1.
- R7: With VARIANT=2, carry_o is (bits_in[0] OR bits_in[1]) AND (bits_in[2] OR bits_in[3]), and sum_o is 1 exactly when bits_in[0] equals bits_in[1] or bits_in[2] equals bits_in[3]. carry_out is always 0, and carry_in has no effect on any output.
- R8: With VARIANT=2, exactly 4 of the 16 patterns of bits_in are wrong. All ones give carry_o=1 and sum_o=1, a value of 3. All zeros give a value of 1.
- R9: err_diff is a two's-complement number of DW bits (default 3). It equals the weighted output value minus the exact value, where the exact value is the count of ones in bits_in plus carry_in, and variant 2 leaves carry_in out of that count. err_diff is always 0 with VARIANT=0 and stays within -1..+1 in the approximate variants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bits_in | input | 4 | Four equal-weight operand bits of this column |
| carry_in | input | 1 | Carry from the column to the right (ignored in variant 2) |
| sum_o | output | 1 | Result bit of weight one |
| carry_o | output | 1 | Result bit of weight two, kept in the same tree row |
| carry_out | output | 1 | Bit of weight two sent to the column on the left (0 in variant 2) |
| err_diff | output | DW | Signed approximate value minus exact value |

## Verification
The bound checker re-evaluates the output equations of each variant every time an input changes. It checks the exact-sum identity in variant 0, the carry-follows-carry-in rule and the forced-zero sum of variant 1, and the dead carry chain of variant 2. It also checks that err_diff agrees with a fresh population count and stays within its range. Some properties only show up across a whole input space, and these are left to the bench's sweeps: the number of wrong patterns per variant (12 of 32 and 4 of 16), the specific values on the all-zero and all-one corners, and the insensitivity of variant 2 to carry_in.

// File: rtl/cmp42_slice.sv
module cmp42_slice #(
  parameter int VARIANT = 0,
  parameter int DW      = 3
) (
  input  logic                 [3:0] bits_in,
  input  logic                       carry_in,
  output logic                       sum_o,
  output logic                       carry_o,
  output logic                       carry_out,
  output logic signed [DW-1:0]       err_diff
);

  logic eq_lo, eq_hi, any_lo, any_hi;
  logic ref_cin;
  logic [DW-1:0] out_val, ref_val;

  assign eq_lo  = ~(bits_in[0] ^ bits_in[1]);
  assign eq_hi  = ~(bits_in[2] ^ bits_in[3]);
  assign any_lo = bits_in[0] | bits_in[1];
  assign any_hi = bits_in[2] | bits_in[3];

  generate
    if (VARIANT == 0) begin : g_exact
      logic s1;
      assign s1        = bits_in[0] ^ bits_in[1] ^ bits_in[2];
      assign carry_out = (bits_in[0] & bits_in[1]) | (bits_in[2] & (bits_in[0] ^ bits_in[1]));
      assign sum_o     = s1 ^ bits_in[3] ^ carry_in;
      assign carry_o   = (s1 & bits_in[3]) | (carry_in & (s1 ^ bits_in[3]));
    end else if (VARIANT == 1) begin : g_apx_chain
      assign carry_o   = carry_in;
      assign sum_o     = ~carry_in & (eq_lo | eq_hi);
      assign carry_out = any_lo & any_hi;
    end else begin : g_apx_nochain
      assign carry_o   = any_lo & any_hi;
      assign sum_o     = eq_lo | eq_hi;
      assign carry_out = 1'b0;
    end
  endgenerate

  assign ref_cin  = (VARIANT == 2) ? 1'b0 : carry_in;
  assign out_val  = DW'(sum_o) + DW'({carry_o, 1'b0}) + DW'({carry_out, 1'b0});
  assign ref_val  = DW'(bits_in[0]) + DW'(bits_in[1]) + DW'(bits_in[2])
                  + DW'(bits_in[3]) + DW'(ref_cin);
  assign err_diff = $signed(out_val - ref_val);

endmodule

// File: rtl/cmp42_slice_chk.sv
module cmp42_slice_chk #(
  parameter int VARIANT = 0,
  parameter int DW      = 3
) (
  input logic                 [3:0] bits_in,
  input logic                       carry_in,
  input logic                       sum_o,
  input logic                       carry_o,
  input logic                       carry_out,
  input logic signed [DW-1:0]       err_diff
);

  logic [3:0] ones;
  logic [3:0] total;
  logic [3:0] weighted;
  logic       maj3;

  assign ones     = {3'b0, bits_in[0]} + {3'b0, bits_in[1]} + {3'b0, bits_in[2]} + {3'b0, bits_in[3]};
  assign total    = ones + ((VARIANT == 2) ? 4'd0 : {3'b0, carry_in});
  assign weighted = {3'b0, sum_o} + {2'b0, carry_o, 1'b0} + {2'b0, carry_out, 1'b0};
  assign maj3     = (bits_in[0] & bits_in[1]) | (bits_in[0] & bits_in[2]) | (bits_in[1] & bits_in[2]);

  always_comb begin
    if (VARIANT == 0) begin
      // R1
      exact_value_chk: assert (weighted == total);
      // R2
      exact_cout_chk: assert (carry_out == maj3);
      // R9
      exact_diff_zero_chk: assert (err_diff == '0);
    end else if (VARIANT == 1) begin
      // R3
      chain_carry_chk: assert (carry_o == carry_in);
      // R4
      chain_sum_zero_chk: assert (!(carry_in && sum_o));
      // R5
      chain_cout_chk: assert (carry_out == ((bits_in[0] | bits_in[1]) & (bits_in[2] | bits_in[3])));
    end else begin
      // R7
      nochain_cout_chk: assert (carry_out == 1'b0);
      // R7
      nochain_carry_chk: assert (carry_o == ((bits_in[0] | bits_in[1]) & (bits_in[2] | bits_in[3])));
    end
    // R9
    diff_value_chk: assert ($unsigned(err_diff) == DW'(weighted - total));
    // R9
    diff_range_chk: assert (err_diff >= -1 && err_diff <= 1);
  end

endmodule

bind cmp42_slice cmp42_slice_chk #(.VARIANT(VARIANT), .DW(DW)) chk_i (.*);

// File: tb/cmp42_slice_test.sv
module cmp42_slice_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] bits;
  logic       cin;
  logic       s0, c0, co0, s1, c1, co1, s2, c2, co2;
  logic signed [2:0] d0, d1, d2;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  cmp42_slice #(.VARIANT(0)) uut (
    .bits_in(bits), .carry_in(cin), .sum_o(s0), .carry_o(c0), .carry_out(co0), .err_diff(d0));
  cmp42_slice #(.VARIANT(1)) uut_chain (
    .bits_in(bits), .carry_in(cin), .sum_o(s1), .carry_o(c1), .carry_out(co1), .err_diff(d1));
  cmp42_slice #(.VARIANT(2)) uut_nochain (
    .bits_in(bits), .carry_in(cin), .sum_o(s2), .carry_o(c2), .carry_out(co2), .err_diff(d2));

  // fields: carry_in, bits_in[3:0], expected value variant 1, expected value variant 2
  localparam logic [10:0] VEC [0:7] = '{
    {1'b0, 4'b0000, 3'd1, 3'd1},
    {1'b0, 4'b1111, 3'd3, 3'd3},
    {1'b0, 4'b0011, 3'd1, 3'd1},
    {1'b0, 4'b0101, 3'd2, 3'd2},
    {1'b1, 4'b0000, 3'd2, 3'd1},
    {1'b1, 4'b1111, 3'd4, 3'd3},
    {1'b1, 4'b0110, 3'd4, 3'd2},
    {1'b1, 4'b0111, 3'd4, 3'd3}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d (cin=%b bits=%b)", tag, act, exp, cin, bits);
    end
  endtask

  task automatic apply(input logic c, input logic [3:0] b);
    @(posedge clk);
    #2;
    cin  = c;
    bits = b;
    #5;
  endtask

  function automatic int popc(input logic [3:0] b);
    return int'(b[0]) + int'(b[1]) + int'(b[2]) + int'(b[3]);
  endfunction

  initial begin
    int err_chain;
    int err_nochain;
    cin  = 1'b0;
    bits = 4'b0000;
    err_chain   = 0;
    err_nochain = 0;

    // initial all-zero state: approximate variants report 1, exact reports 0 (R1, R6, R8)
    #7;
    chk("R1 zero-input exact value", int'(s0) + 2*int'(c0) + 2*int'(co0), 0);
    chk("R6 zero-input chain sum", int'(s1), 1);
    chk("R8 zero-input nochain sum", int'(s2), 1);

    // exhaustive sweep against the requirement equations
    for (int i = 0; i < 32; i++) begin
      logic c;
      logic [3:0] b;
      int n;
      int v0, v1, v2;
      logic eql, eqh, orand;
      c = i[4];
      b = i[3:0];
      apply(c, b);
      n     = popc(b);
      eql   = (b[0] == b[1]);
      eqh   = (b[2] == b[3]);
      orand = (b[0] | b[1]) & (b[2] | b[3]);
      v0 = int'(s0) + 2*int'(c0) + 2*int'(co0);
      v1 = int'(s1) + 2*int'(c1) + 2*int'(co1);
      v2 = int'(s2) + 2*int'(c2) + 2*int'(co2);
      chk("R1 exact weighted value", v0, n + int'(c));
      chk("R2 exact carry_out majority", int'(co0),
          int'((b[0] & b[1]) | (b[0] & b[2]) | (b[1] & b[2])));
      chk("R3 chain carry follows carry_in", int'(c1), int'(c));
      chk("R4 chain sum", int'(s1), c ? 0 : int'(eql | eqh));
      chk("R5 chain carry_out", int'(co1), int'(orand));
      chk("R7 nochain carry", int'(c2), int'(orand));
      chk("R7 nochain sum", int'(s2), int'(eql | eqh));
      chk("R7 nochain carry_out low", int'(co2), 0);
      chk("R9 exact diff", int'(d0), 0);
      chk("R9 chain diff", int'(d1), v1 - (n + int'(c)));
      chk("R9 nochain diff", int'(d2), v2 - n);
      if (v1 != n + int'(c)) err_chain++;
      if (!c && v2 != n) err_nochain++;
    end
    chk("R6 chain wrong-pattern count", err_chain, 12);
    chk("R8 nochain wrong-pattern count", err_nochain, 4);

    // R7: carry_in has no effect in variant 2
    for (int i = 0; i < 16; i++) begin
      logic ra, rb, rc;
      apply(1'b0, i[3:0]);
      ra = s2; rb = c2; rc = co2;
      apply(1'b1, i[3:0]);
      chk("R7 nochain ignores carry_in", int'({s2, c2, co2}), int'({ra, rb, rc}));
    end

    // directed corner vectors (R6, R8, R1)
    for (int k = 0; k < 8; k++) begin
      apply(VEC[k][10], VEC[k][9:6]);
      chk("R6 chain corner value", int'(s1) + 2*int'(c1) + 2*int'(co1), int'(VEC[k][5:3]));
      chk("R8 nochain corner value", int'(s2) + 2*int'(c2) + 2*int'(co2), int'(VEC[k][2:0]));
      chk("R1 exact corner value", int'(s0) + 2*int'(c0) + 2*int'(co0),
          popc(VEC[k][9:6]) + int'(VEC[k][10]));
    end

    // R8: all ones gives carry=1 and sum=1
    apply(1'b0, 4'b1111);
    chk("R8 all-ones carry", int'(c2), 1);
    chk("R8 all-ones sum", int'(s2), 1);
    chk("R9 all-ones nochain diff", int'(d2), -1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule